// File: doc/BRIEF.md
# PLL Control and Lock Interrupt Register Block

This block holds the software-visible control state of a clock-multiplier PLL. A simple synchronous register bus writes and reads it. The bus has an address, a write strobe, a read strobe, write data and read data. The block keeps the following state: the PLL run bit, the bit that selects the PLL as the base clock, an interrupt enable, an automatic-mode bit, a multiplier field and a 4-bit VCO range field. The analog loop, the VCO and the clock mux sit outside the block.

The multiplier and range fields are frozen while the PLL runs. A range of zero counts as a disabled loop, so the clock-select bit cannot be set while the range is zero. The clock-select bit may still be set while the loop is not locked. The lock indication from the analog side is asynchronous. It is resynchronized, and in automatic mode each change of lock, in either direction, sets an interrupt flag. The flag is cleared by reading the control register. The interrupt request is the flag gated by the enable bit. A registered copy of the clock-select bit drives the external clock mux.

Top module: `pll_ctrl_regs`

## Requirements
- R1: A write to the multiplier field (offset 2, bits [7:0]) has no effect while the run bit is 1.
- R2: A write to the range field (offset 3, bits [3:0]) has no effect while the run bit is 1.
- R3: After reset the range field reads 6 and the multiplier field reads 1. All control bits, the automatic bit, the flag and both outputs read 0.
- R4: While the range field is 0 the clock-select bit stays 0, even when a control write asks to set it.
- R5: With the automatic bit set, a rise or a fall of the lock input sets the flag, whatever the interrupt enable is. The flag becomes visible in the third clock after the lock input changes.
- R6: With the automatic bit clear, the flag reads 0 and the interrupt request is 0, even when the lock input changes.
- R7: The interrupt request output is high exactly when the visible flag and the interrupt enable are both 1.
- R8: A control write sets the clock-select bit while the lock input is 0, provided the run bit is written as 1 and the range is nonzero.
- R9: A read of the control register (offset 0) clears the flag. If a lock change sets the flag in the same clock as that read, the flag ends up set.
- R10: Register map. Offset 0 is control: bit0 run, bit1 clock select, bit2 interrupt enable, bit3 flag (read-only). Offset 1 holds bit0 automatic and bit1 synchronized lock (read-only). Offset 2 is the multiplier. Offset 3 holds the range in bits [3:0]. Bits not listed read 0.
- R11: A control write with the run bit 0 clears the clock-select bit. The clock-select output follows the clock-select bit one clock later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 2 | Register offset |
| bus_we | input | 1 | Write strobe |
| bus_re | input | 1 | Read strobe (clears the flag on offset 0) |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the addressed register |
| lock_async | input | 1 | Lock indication from the analog PLL, asynchronous |
| clk_sel_o | output | 1 | Registered clock-select drive to the external mux |
| irq_o | output | 1 | Interrupt request |

## Verification
Suppose a frozen field were wrongly updated while the PLL runs. The next read of offset 2 or 3 would return the new value, and an assertion would fail at the clock after the write. A broken change detector or flag would show as a wrong bit3 on the next control read, three clocks after a lock edge, and as a wrong irq_o on the same clock. A clock-select bit that escapes its guards would appear on clk_sel_o one clock after the write that caused it.

// File: rtl/pllcr_pkg.sv
package pllcr_pkg;

    localparam int ADDR_W  = 2;
    localparam int DATA_W  = 8;
    localparam int RANGE_W = 4;

    typedef enum logic [ADDR_W-1:0] {
        OFS_CTRL  = 2'd0,
        OFS_BW    = 2'd1,
        OFS_MUL   = 2'd2,
        OFS_RANGE = 2'd3
    } reg_ofs_e;

    // control register bit positions
    localparam int B_RUN  = 0;
    localparam int B_CSEL = 1;
    localparam int B_IEN  = 2;
    localparam int B_FLAG = 3;
    // bandwidth register bit positions
    localparam int B_AUTO = 0;
    localparam int B_LOCK = 1;

    typedef struct packed {
        logic run;
        logic csel;
        logic ien;
    } ctrl_t;

    localparam ctrl_t CTRL_RST = '{run: 1'b0, csel: 1'b0, ien: 1'b0};

    function automatic logic range_live(input logic [RANGE_W-1:0] r);
        return (r != '0);
    endfunction

    // next clock-select value for a control write
    function automatic logic csel_next(input logic [DATA_W-1:0] wd,
                                       input logic [RANGE_W-1:0] r);
        return wd[B_CSEL] & wd[B_RUN] & range_live(r);
    endfunction

endpackage

// File: rtl/pllcr_lock_sync.sv
module pllcr_lock_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic lock_in,
    output logic lock_sync,
    output logic lock_chg
);
    logic [STAGES-1:0] stage_q;
    logic              prev_q;

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            always_ff @(posedge clk) begin
                if (rst) begin
                    stage_q[i] <= 1'b0;
                end else if (i == 0) begin
                    stage_q[i] <= lock_in;
                end else begin
                    stage_q[i] <= stage_q[(i == 0) ? 0 : i-1];
                end
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_q <= 1'b0;
        end else begin
            prev_q <= stage_q[STAGES-1];
        end
    end

    assign lock_sync = stage_q[STAGES-1];
    assign lock_chg  = stage_q[STAGES-1] ^ prev_q;

endmodule

// File: rtl/pllcr_fields.sv
module pllcr_fields
    import pllcr_pkg::*;
#(
    parameter int                  MUL_W     = 8,
    parameter logic [MUL_W-1:0]    MUL_RST   = 1,
    parameter logic [RANGE_W-1:0]  RANGE_RST = 6
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               we,
    input  logic [ADDR_W-1:0]  addr,
    input  logic [DATA_W-1:0]  wdata,
    output ctrl_t              ctrl,
    output logic               auto_mode,
    output logic [MUL_W-1:0]   mul,
    output logic [RANGE_W-1:0] range
);
    ctrl_t              ctrl_q, ctrl_d;
    logic               auto_q, auto_d;
    logic [MUL_W-1:0]   mul_q, mul_d;
    logic [RANGE_W-1:0] range_q, range_d;
    logic               frozen;

    assign frozen = ctrl_q.run;

    always_comb begin
        ctrl_d  = ctrl_q;
        auto_d  = auto_q;
        mul_d   = mul_q;
        range_d = range_q;
        if (we) begin
            case (reg_ofs_e'(addr))
                OFS_CTRL: begin
                    ctrl_d.run  = wdata[B_RUN];
                    ctrl_d.ien  = wdata[B_IEN];
                    ctrl_d.csel = csel_next(wdata, range_q);
                end
                OFS_BW: begin
                    auto_d = wdata[B_AUTO];
                end
                OFS_MUL: begin
                    if (!frozen) begin
                        mul_d = wdata[MUL_W-1:0];
                    end
                end
                OFS_RANGE: begin
                    if (!frozen) begin
                        range_d = wdata[RANGE_W-1:0];
                    end
                end
                default: ;
            endcase
        end
        // a dead range never lets the loop drive the base clock
        if (!range_live(range_d)) begin
            ctrl_d.csel = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q  <= CTRL_RST;
            auto_q  <= 1'b0;
            mul_q   <= MUL_RST;
            range_q <= RANGE_RST;
        end else begin
            ctrl_q  <= ctrl_d;
            auto_q  <= auto_d;
            mul_q   <= mul_d;
            range_q <= range_d;
        end
    end

    assign ctrl      = ctrl_q;
    assign auto_mode = auto_q;
    assign mul       = mul_q;
    assign range     = range_q;

endmodule

// File: rtl/pllcr_flag.sv
module pllcr_flag (
    input  logic clk,
    input  logic rst,
    input  logic auto_mode,
    input  logic lock_chg,
    input  logic rd_clr,
    output logic flag
);
    logic flag_q, flag_d;

    always_comb begin
        if (!auto_mode) begin
            flag_d = 1'b0;
        end else if (lock_chg) begin
            flag_d = 1'b1;          // set beats a same-cycle clear
        end else if (rd_clr) begin
            flag_d = 1'b0;
        end else begin
            flag_d = flag_q;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            flag_q <= 1'b0;
        end else begin
            flag_q <= flag_d;
        end
    end

    assign flag = flag_q;

endmodule

// File: rtl/pll_ctrl_regs.sv
module pll_ctrl_regs
    import pllcr_pkg::*;
#(
    parameter int                  MUL_W       = 8,
    parameter logic [MUL_W-1:0]    MUL_RST     = 1,
    parameter logic [RANGE_W-1:0]  RANGE_RST   = 6,
    parameter int                  SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic              bus_re,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              lock_async,
    output logic              clk_sel_o,
    output logic              irq_o
);
    ctrl_t              ctrl;
    logic               auto_mode;
    logic [MUL_W-1:0]   mul;
    logic [RANGE_W-1:0] range;
    logic               lock_sync;
    logic               lock_chg;
    logic               flag_raw;
    logic               flag_vis;
    logic               rd_clr;
    logic               pll_run;
    logic               csel_bit;
    logic               ien_bit;
    logic               csel_q;

    pllcr_lock_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk       (clk),
        .rst       (rst),
        .lock_in   (lock_async),
        .lock_sync (lock_sync),
        .lock_chg  (lock_chg)
    );

    pllcr_fields #(
        .MUL_W     (MUL_W),
        .MUL_RST   (MUL_RST),
        .RANGE_RST (RANGE_RST)
    ) u_fields (
        .clk       (clk),
        .rst       (rst),
        .we        (bus_we),
        .addr      (bus_addr),
        .wdata     (bus_wdata),
        .ctrl      (ctrl),
        .auto_mode (auto_mode),
        .mul       (mul),
        .range     (range)
    );

    assign rd_clr = bus_re && (reg_ofs_e'(bus_addr) == OFS_CTRL);

    pllcr_flag u_flag (
        .clk       (clk),
        .rst       (rst),
        .auto_mode (auto_mode),
        .lock_chg  (lock_chg),
        .rd_clr    (rd_clr),
        .flag      (flag_raw)
    );

    assign pll_run  = ctrl.run;
    assign csel_bit = ctrl.csel;
    assign ien_bit  = ctrl.ien;
    assign flag_vis = flag_raw & auto_mode;

    always_comb begin
        bus_rdata = '0;
        case (reg_ofs_e'(bus_addr))
            OFS_CTRL: begin
                bus_rdata[B_RUN]  = ctrl.run;
                bus_rdata[B_CSEL] = ctrl.csel;
                bus_rdata[B_IEN]  = ctrl.ien;
                bus_rdata[B_FLAG] = flag_vis;
            end
            OFS_BW: begin
                bus_rdata[B_AUTO] = auto_mode;
                bus_rdata[B_LOCK] = lock_sync;
            end
            OFS_MUL:   bus_rdata[MUL_W-1:0]   = mul;
            OFS_RANGE: bus_rdata[RANGE_W-1:0] = range;
            default:   bus_rdata = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            csel_q <= 1'b0;
        end else begin
            csel_q <= ctrl.csel;
        end
    end

    assign clk_sel_o = csel_q;
    assign irq_o     = flag_vis & ctrl.ien;

endmodule

// File: rtl/pllcr_checker.sv
module pllcr_checker #(
    parameter int MUL_W = 8
) (
    input logic             clk,
    input logic             rst,
    input logic             pll_run,
    input logic             csel_bit,
    input logic             ien_bit,
    input logic             auto_mode,
    input logic             flag_raw,
    input logic             lock_chg,
    input logic [MUL_W-1:0] mul,
    input logic [3:0]       range,
    input logic             irq_o,
    input logic             clk_sel_o
);
    assert_mul_frozen_R1: assert property (@(posedge clk) disable iff (rst)
        pll_run |=> $stable(mul));

    assert_range_frozen_R2: assert property (@(posedge clk) disable iff (rst)
        pll_run |=> $stable(range));

    assert_zero_range_R4: assert property (@(posedge clk) disable iff (rst)
        (range == 4'd0) |-> !csel_bit);

    assert_flag_set_R5: assert property (@(posedge clk) disable iff (rst)
        (auto_mode && lock_chg) |=> flag_raw);

    assert_noauto_flag_R6: assert property (@(posedge clk) disable iff (rst)
        !auto_mode |=> !flag_raw);

    assert_noauto_irq_R6: assert property (@(posedge clk) disable iff (rst)
        !auto_mode |-> !irq_o);

    assert_irq_cause_R7: assert property (@(posedge clk) disable iff (rst)
        irq_o |-> (ien_bit && flag_raw));

    assert_run_off_R11: assert property (@(posedge clk) disable iff (rst)
        !pll_run |-> !csel_bit);

    assert_out_lag_R11: assert property (@(posedge clk) disable iff (rst)
        clk_sel_o == $past(csel_bit));

endmodule

bind pll_ctrl_regs pllcr_checker #(.MUL_W(MUL_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .pll_run   (pll_run),
    .csel_bit  (csel_bit),
    .ien_bit   (ien_bit),
    .auto_mode (auto_mode),
    .flag_raw  (flag_raw),
    .lock_chg  (lock_chg),
    .mul       (mul),
    .range     (range),
    .irq_o     (irq_o),
    .clk_sel_o (clk_sel_o)
);

// File: tb/pll_ctrl_regs_test.sv
module pll_ctrl_regs_test;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [1:0] bus_addr = '0;
    logic       bus_we = 1'b0;
    logic       bus_re = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic       lock_async = 1'b0;
    logic       clk_sel_o;
    logic       irq_o;

    int checks = 0;
    int fails  = 0;

    // requirement-level model
    logic       m_run, m_csel, m_ien, m_auto, m_flag, m_lock;
    logic [7:0] m_mul;
    logic [3:0] m_range;

    always #4 clk = ~clk;

    pll_ctrl_regs uut (
        .clk        (clk),
        .rst        (rst),
        .bus_addr   (bus_addr),
        .bus_we     (bus_we),
        .bus_re     (bus_re),
        .bus_wdata  (bus_wdata),
        .bus_rdata  (bus_rdata),
        .lock_async (lock_async),
        .clk_sel_o  (clk_sel_o),
        .irq_o      (irq_o)
    );

    task automatic summary();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] exp_read(input logic [1:0] a);
        case (a)
            2'd0:    return {4'b0, m_flag & m_auto, m_ien, m_csel, m_run};
            2'd1:    return {6'b0, m_lock, m_auto};
            2'd2:    return m_mul;
            default: return {4'b0, m_range};
        endcase
    endfunction

    function automatic void model_write(input logic [1:0] a, input logic [7:0] d);
        case (a)
            2'd0: begin
                m_run  = d[0];
                m_ien  = d[2];
                m_csel = d[1] & d[0] & (m_range != 4'd0);
            end
            2'd1: begin
                m_auto = d[0];
                if (!d[0]) m_flag = 1'b0;
            end
            2'd2: if (!m_run) m_mul = d;
            default: if (!m_run) m_range = d[3:0];
        endcase
    endfunction

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
        model_write(a, d);
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] v);
        @(negedge clk);
        bus_re = 1'b1; bus_addr = a;
        #1 v = bus_rdata;
        @(negedge clk);
        bus_re = 1'b0;
    endtask

    task automatic rd_chk(input string req, input logic [1:0] a);
        logic [7:0] v;
        rd(a, v);
        chk(req, v, exp_read(a));
        if (a == 2'd0) m_flag = 1'b0;
    endtask

    task automatic toggle_lock();
        @(negedge clk);
        lock_async = ~lock_async;
        repeat (4) @(negedge clk);
        m_lock = lock_async;
        if (m_auto) m_flag = 1'b1;
    endtask

    task automatic out_chk(input string req);
        @(negedge clk);
        chk({req, " clk_sel_o"}, {7'b0, clk_sel_o}, {7'b0, m_csel});
        chk({req, " irq_o"}, {7'b0, irq_o}, {7'b0, m_flag & m_auto & m_ien});
    endtask

    initial begin
        #(8 * 200000);
        checks++; fails++;
        $display("FAIL watchdog actual=running expected=done");
        summary();
    end

    initial begin
        logic [7:0] v;
        void'($urandom(32'd4242));
        m_run = 0; m_csel = 0; m_ien = 0; m_auto = 0; m_flag = 0; m_lock = 0;
        m_mul = 8'd1; m_range = 4'd6;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R3 reset state
        rd_chk("R3 ctrl", 2'd0);
        rd_chk("R3 bw", 2'd1);
        rd_chk("R3 mul", 2'd2);
        rd_chk("R3 range", 2'd3);
        out_chk("R3");

        // R8 select with lock absent, R11 output lag
        wr(2'd0, 8'h03);
        chk("R11 lag before", {7'b0, clk_sel_o}, 8'h00);
        out_chk("R8");
        rd_chk("R8 ctrl", 2'd0);

        // R1 R2 frozen fields while running
        wr(2'd2, 8'h5a);
        wr(2'd3, 8'h02);
        rd_chk("R1 mul", 2'd2);
        rd_chk("R2 range", 2'd3);

        // R11 clear run clears select
        wr(2'd0, 8'h02);
        out_chk("R11");
        rd_chk("R11 ctrl", 2'd0);

        // R4 zero range blocks select
        wr(2'd3, 8'h00);
        wr(2'd0, 8'h03);
        rd_chk("R4 ctrl", 2'd0);
        out_chk("R4");
        wr(2'd0, 8'h00);
        wr(2'd3, 8'hf7);
        rd_chk("R10 range unused bits", 2'd3);

        // R6 no flag without automatic mode
        wr(2'd0, 8'h04);
        toggle_lock();
        out_chk("R6");
        rd_chk("R6 ctrl", 2'd0);

        // R5 both edges, interrupt disabled
        wr(2'd1, 8'hff);
        rd_chk("R10 bw unused bits", 2'd1);
        wr(2'd0, 8'h00);
        toggle_lock();
        out_chk("R5 fall");
        rd_chk("R5 fall flag", 2'd0);
        toggle_lock();
        rd_chk("R5 rise flag", 2'd0);

        // R7 request with enable
        wr(2'd0, 8'h04);
        toggle_lock();
        out_chk("R7");
        chk("R7 irq high", {7'b0, irq_o}, 8'h01);
        rd_chk("R9 read clears", 2'd0);
        rd_chk("R9 stays clear", 2'd0);

        // R9 set wins over a same-cycle clear
        @(negedge clk);
        lock_async = ~lock_async;
        @(posedge clk); @(posedge clk);
        rd(2'd0, v);
        chk("R9 race read", v, 8'h04);
        m_lock = lock_async; m_flag = 1'b1;
        rd_chk("R9 set wins", 2'd0);

        // random mix
        for (int i = 0; i < 400; i++) begin
            int op;
            logic [1:0] a;
            logic [7:0] d;
            op = $urandom_range(0, 5);
            a  = 2'($urandom_range(0, 3));
            d  = 8'($urandom);
            case (op)
                0, 1, 2: wr(a, d);
                3:       toggle_lock();
                4:       rd_chk("R10 random read", a);
                default: out_chk("R7 random");
            endcase
        end
        for (int a = 0; a < 4; a++) rd_chk("R10 final", 2'(a));
        summary();
    end

endmodule